// File: doc/BRIEF.md
# DRAM Bank-Select Column-Strobe Steering Decoder

This block sits between a single host DRAM controller and a row of identical 1M x 16 fast-page-mode DRAM chips, so that the host can address more memory than one chip provides. The host drives its row strobe, its low-byte and high-byte column strobes, and two extra high address lines. The block reads those two lines as a bank code when the row strobe falls. It then passes the column strobes to the chip that code names. The other chips see a row access with no column strobe, and that leaves their contents untouched.

The row strobe reaches every chip unchanged. If the host asserts a column strobe while the row strobe is still high, the cycle is a CAS-before-RAS refresh. In that case every chip receives the column strobes until the refresh ends. The gating is combinational, so the steered strobes add no clock cycles to the host's timing. A clock is used only to detect the row-strobe fall, to hold the bank code and to remember that a refresh is in progress. The chip count is a parameter, either 2 or 4.

Top module: `dram_cas_steer`

## Requirements
- R1: While `rst_n` is low, every bit of `chip_cas_lo_n` and `chip_cas_hi_n` is 1, whatever the strobe inputs are.
- R2: Every bit of `chip_ras_n` equals `ras_n` at all times.
- R3: On the first clock edge at which `ras_n` is sampled low after being high, the bank code is taken from `bank_addr`, with bit 0 as the low extra line and bit 1 as the high one. Chip index `bank_addr` (4 chips) becomes selected. In the same cycle in which `ras_n` falls, the column strobes already reach the chip named by the live `bank_addr`.
- R4: While `ras_n` is low and no refresh is in progress, the selected chip's `chip_cas_lo_n` and `chip_cas_hi_n` each follow `cas_lo_n` and `cas_hi_n` independently. Every other chip holds both of its outputs at 1.
- R5: While `ras_n` stays low, changes on `bank_addr` have no effect. Every column-strobe pulse of a page-mode burst reaches the same chip.
- R6: When `cas_lo_n` or `cas_hi_n` is low while `ras_n` is high, every chip's column outputs follow the column-strobe inputs. This broadcast continues while `ras_n` is low and ends only once `ras_n` is high with both column strobes high. The host must hold this column strobe for at least one clock edge before it lowers `ras_n`.
- R7: With `ras_n` high and both column strobes high, every column output is 1. After a refresh ends, the next row cycle steers normally again.
- R8: With `NUM_CHIPS` = 2, `bank_addr[1]` is ignored and `bank_addr[0]` alone picks chip 0 or chip 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for edge detection and held state |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Host row strobe, active low |
| cas_lo_n | input | 1 | Host low-byte column strobe, active low |
| cas_hi_n | input | 1 | Host high-byte column strobe, active low |
| bank_addr | input | 2 | Extra high address lines forming the bank code |
| chip_ras_n | output | NUM_CHIPS | Row strobe fanned out to each chip |
| chip_cas_lo_n | output | NUM_CHIPS | Per-chip low-byte column strobe, active low |
| chip_cas_hi_n | output | NUM_CHIPS | Per-chip high-byte column strobe, active low |

## Verification
The row-strobe fall that captures the bank code and the column-strobe steering that uses that code can land in the same cycle. The bench provokes this by lowering `ras_n` and both column strobes in one step from idle. It expects the strobes on the chip named by the live address in that cycle, and on the same chip after the code has been registered. A second overlap is refresh detection against a row fall: the bench lowers `ras_n` one cycle after a column strobe and then moves `bank_addr`. It judges that all chips keep receiving the strobes, and that the next ordinary access goes back to a single chip.

// File: rtl/dram_steer_pkg.sv
package dram_steer_pkg;

  localparam int unsigned MAX_CHIPS = 4;
  localparam int unsigned CODE_W    = 2;

  // Reduce the raw extra address lines to a chip index for the configured count.
  // With two chips only the lower line is meaningful.
  function automatic logic [CODE_W-1:0] bank_index(input logic [CODE_W-1:0] lines,
                                                   input int unsigned       n_chips);
    logic [CODE_W-1:0] idx;
    if (n_chips == 2) idx = {1'b0, lines[0]};
    else              idx = lines;
    return idx;
  endfunction

  // One-hot chip mask for an index.
  function automatic logic [MAX_CHIPS-1:0] chip_mask(input logic [CODE_W-1:0] idx);
    logic [MAX_CHIPS-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/cas_bank_latch.sv
module cas_bank_latch
  import dram_steer_pkg::*;
#(
  parameter int unsigned NUM_CHIPS = 4,
  localparam int unsigned IDX_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic [CODE_W-1:0] bank_addr,
  output logic              ras_fall,
  output logic [IDX_W-1:0]  held_idx,
  output logic [IDX_W-1:0]  sel_idx
);

  logic              ras_q;
  logic [CODE_W-1:0] live_code;
  logic [IDX_W-1:0]  live_idx;

  assign live_code = bank_index(bank_addr, NUM_CHIPS);
  assign live_idx  = live_code[IDX_W-1:0];
  assign ras_fall  = ras_q && !ras_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      held_idx <= '0;
    end else begin
      ras_q <= ras_n;
      if (ras_fall) held_idx <= live_idx;
    end
  end

  // During the fall cycle the live code is used so steering costs no edge.
  assign sel_idx = ras_fall ? live_idx : held_idx;

endmodule

// File: rtl/cbr_refresh_track.sv
module cbr_refresh_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_any,
  output logic refresh_q,
  output logic bcast
);

  logic cbr_start;
  logic cbr_end;

  assign cbr_start = ras_n && cas_any;
  assign cbr_end   = ras_n && !cas_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         refresh_q <= 1'b0;
    else if (cbr_start) refresh_q <= 1'b1;
    else if (cbr_end)   refresh_q <= 1'b0;
  end

  assign bcast = refresh_q || cbr_start;

endmodule

// File: rtl/cas_lane_gate.sv
module cas_lane_gate #(
  parameter int unsigned NUM_CHIPS = 4,
  localparam int unsigned IDX_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic                 rst_n,
  input  logic                 ras_n,
  input  logic                 cas_lo_n,
  input  logic                 cas_hi_n,
  input  logic                 bcast,
  input  logic [IDX_W-1:0]     sel_idx,
  output logic [NUM_CHIPS-1:0] chip_en,
  output logic [NUM_CHIPS-1:0] chip_cas_lo_n,
  output logic [NUM_CHIPS-1:0] chip_cas_hi_n
);

  for (genvar k = 0; k < NUM_CHIPS; k++) begin : g_lane
    assign chip_en[k] = rst_n && (bcast || (!ras_n && (sel_idx == IDX_W'(k))));
    assign chip_cas_lo_n[k] = chip_en[k] ? cas_lo_n : 1'b1;
    assign chip_cas_hi_n[k] = chip_en[k] ? cas_hi_n : 1'b1;
  end

endmodule

// File: rtl/dram_cas_steer.sv
module dram_cas_steer
  import dram_steer_pkg::*;
#(
  parameter int unsigned NUM_CHIPS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras_n,
  input  logic                 cas_lo_n,
  input  logic                 cas_hi_n,
  input  logic [1:0]           bank_addr,
  output logic [NUM_CHIPS-1:0] chip_ras_n,
  output logic [NUM_CHIPS-1:0] chip_cas_lo_n,
  output logic [NUM_CHIPS-1:0] chip_cas_hi_n
);

  localparam int unsigned IDX_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;

  // Named internal events, visible to the bound checker.
  logic                 ras_fall;
  logic                 refresh_q;
  logic                 bcast;
  logic                 cas_any;
  logic [IDX_W-1:0]     held_idx;
  logic [IDX_W-1:0]     sel_idx;
  logic [NUM_CHIPS-1:0] chip_en;

  assign cas_any    = !cas_lo_n || !cas_hi_n;
  assign chip_ras_n = {NUM_CHIPS{ras_n}};

  cas_bank_latch #(.NUM_CHIPS(NUM_CHIPS)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .bank_addr (bank_addr),
    .ras_fall  (ras_fall),
    .held_idx  (held_idx),
    .sel_idx   (sel_idx)
  );

  cbr_refresh_track refresh_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_any   (cas_any),
    .refresh_q (refresh_q),
    .bcast     (bcast)
  );

  cas_lane_gate #(.NUM_CHIPS(NUM_CHIPS)) gate_i (
    .rst_n         (rst_n),
    .ras_n         (ras_n),
    .cas_lo_n      (cas_lo_n),
    .cas_hi_n      (cas_hi_n),
    .bcast         (bcast),
    .sel_idx       (sel_idx),
    .chip_en       (chip_en),
    .chip_cas_lo_n (chip_cas_lo_n),
    .chip_cas_hi_n (chip_cas_hi_n)
  );

endmodule

// File: rtl/dram_cas_steer_chk.sv
module dram_cas_steer_chk
  import dram_steer_pkg::*;
#(
  parameter int unsigned NUM_CHIPS = 4,
  localparam int unsigned IDX_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ras_n,
  input logic                 cas_lo_n,
  input logic                 cas_hi_n,
  input logic [1:0]           bank_addr,
  input logic [NUM_CHIPS-1:0] chip_ras_n,
  input logic [NUM_CHIPS-1:0] chip_cas_lo_n,
  input logic [NUM_CHIPS-1:0] chip_cas_hi_n,
  input logic                 refresh_q,
  input logic [IDX_W-1:0]     held_idx
);

  logic [CODE_W-1:0] exp_code;
  assign exp_code = bank_index(bank_addr, NUM_CHIPS);

  initial begin
    assert_legal_count_R8: assert (NUM_CHIPS == 2 || NUM_CHIPS == 4);
  end

  // R1: quiet outputs during reset
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      assert_reset_quiet_R1: assert (&chip_cas_lo_n && &chip_cas_hi_n);
    end
  end

  assert_ras_fanout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chip_ras_n == {NUM_CHIPS{ras_n}});

  assert_fall_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(ras_n) && !refresh_q && !cas_lo_n)
      |-> !chip_cas_lo_n[exp_code[IDX_W-1:0]]);

  assert_single_chip_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !refresh_q) |-> ($countones(~chip_cas_lo_n) <= 1));

  assert_single_chip_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !refresh_q) |-> ($countones(~chip_cas_hi_n) <= 1));

  assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n)) |=> (!ras_n -> $stable(held_idx)));

  assert_refresh_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_q && !cas_lo_n && !cas_hi_n)
      |-> (chip_cas_lo_n == '0 && chip_cas_hi_n == '0));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_lo_n && cas_hi_n) |-> (&chip_cas_lo_n && &chip_cas_hi_n));

endmodule

bind dram_cas_steer dram_cas_steer_chk #(.NUM_CHIPS(NUM_CHIPS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .ras_n         (ras_n),
  .cas_lo_n      (cas_lo_n),
  .cas_hi_n      (cas_hi_n),
  .bank_addr     (bank_addr),
  .chip_ras_n    (chip_ras_n),
  .chip_cas_lo_n (chip_cas_lo_n),
  .chip_cas_hi_n (chip_cas_hi_n),
  .refresh_q     (refresh_q),
  .held_idx      (held_idx)
);

// File: tb/dram_cas_steer_tb_top.sv
module dram_cas_steer_tb_top;

  localparam int NONE = -1;
  localparam int ALL  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1;
  logic cas_lo_n = 1'b1;
  logic cas_hi_n = 1'b1;
  logic [1:0] bank_addr = 2'd0;

  logic [3:0] ras4, lo4, hi4;
  logic [1:0] ras2, lo2, hi2;

  always #2 clk = ~clk; // 250 MHz

  dram_cas_steer #(.NUM_CHIPS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
    .cas_hi_n(cas_hi_n), .bank_addr(bank_addr),
    .chip_ras_n(ras4), .chip_cas_lo_n(lo4), .chip_cas_hi_n(hi4));

  dram_cas_steer #(.NUM_CHIPS(2)) dut2_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
    .cas_hi_n(cas_hi_n), .bank_addr(bank_addr),
    .chip_ras_n(ras2), .chip_cas_lo_n(lo2), .chip_cas_hi_n(hi2));

  typedef struct {
    logic [3:0] lo4, hi4, ras4;
    logic [1:0] lo2, hi2, ras2;
    string      req;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Expected lane value: the lane sees the host strobe only when it is a target.
  function automatic logic lane(input int tgt, input int k, input logic s);
    return (tgt == ALL || tgt == k) ? s : 1'b1;
  endfunction

  // Driver: apply one host step at the falling edge and queue what the chips should see.
  task automatic step(input logic r, input logic lo, input logic hi,
                      input logic [1:0] a, input int t4, input int t2,
                      input string req);
    exp_t e;
    @(negedge clk);
    ras_n = r; cas_lo_n = lo; cas_hi_n = hi; bank_addr = a;
    for (int k = 0; k < 4; k++) begin
      e.lo4[k] = lane(t4, k, lo);
      e.hi4[k] = lane(t4, k, hi);
      e.ras4[k] = r;
    end
    for (int k = 0; k < 2; k++) begin
      e.lo2[k] = lane(t2, k, lo);
      e.hi2[k] = lane(t2, k, hi);
      e.ras2[k] = r;
    end
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic cmp(input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Monitor: sample 1 ns after the drive edge, before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp(e.req, "lo4",  lo4,  e.lo4);
        cmp(e.req, "hi4",  hi4,  e.hi4);
        cmp("R2",  "ras4", ras4, e.ras4);
        cmp(e.req, "lo2",  {2'b00, lo2}, {2'b00, e.lo2});
        cmp(e.req, "hi2",  {2'b00, hi2}, {2'b00, e.hi2});
        cmp("R2",  "ras2", {2'b00, ras2}, {2'b00, e.ras2});
      end
    end
  end

  initial begin
    // R1: strobes wiggling during reset reach no chip
    step(1, 0, 0, 2'd3, NONE, NONE, "R1");
    step(0, 0, 1, 2'd1, NONE, NONE, "R1");
    step(1, 1, 1, 2'd0, NONE, NONE, "R1");
    @(negedge clk); rst_n = 1'b1;

    // R7: idle
    step(1, 1, 1, 2'd2, NONE, NONE, "R7");

    // R3/R4: normal access to chip 2 (2-chip build: bit0=0 -> chip 0, R8)
    step(0, 1, 1, 2'd2, 2, 0, "R3");
    step(0, 0, 1, 2'd2, 2, 0, "R4");
    step(0, 1, 0, 2'd2, 2, 0, "R4");
    step(0, 0, 0, 2'd1, 2, 0, "R5");   // address moves mid-cycle
    step(1, 1, 1, 2'd1, NONE, NONE, "R7");

    // R5: page-mode burst to chip 3 (2-chip: chip 1) with address wiggling
    step(0, 1, 1, 2'd3, 3, 1, "R3");
    for (int i = 0; i < 6; i++) begin
      step(0, i[0], ~i[0], 2'(i), 3, 1, "R5");
      step(0, 1, 1, 2'(i + 1), 3, 1, "R5");
    end
    step(1, 1, 1, 2'd0, NONE, NONE, "R7");

    // R3: row fall and both column strobes in the same cycle, live code 1
    step(0, 0, 0, 2'd1, 1, 1, "R3");
    step(0, 0, 0, 2'd0, 1, 1, "R3");
    step(1, 1, 1, 2'd0, NONE, NONE, "R7");

    // R8: A11 ignored in 2-chip build; code 2 -> 4-chip chip 2, 2-chip chip 0
    step(0, 0, 0, 2'd2, 2, 0, "R8");
    step(1, 1, 1, 2'd2, NONE, NONE, "R7");

    // R6: CAS-before-RAS refresh
    step(1, 0, 0, 2'd0, ALL, ALL, "R6");
    step(0, 0, 0, 2'd2, ALL, ALL, "R6");
    step(0, 0, 0, 2'd3, ALL, ALL, "R6");
    step(0, 1, 0, 2'd1, ALL, ALL, "R6");
    step(0, 1, 1, 2'd1, ALL, ALL, "R6");
    step(1, 1, 1, 2'd1, NONE, NONE, "R7");

    // R7: steering back to one chip after refresh
    step(0, 1, 1, 2'd0, 0, 0, "R7");
    step(0, 0, 0, 2'd3, 0, 0, "R7");
    step(1, 1, 1, 2'd0, NONE, NONE, "R7");

    // R6: refresh with only the high-byte strobe
    step(1, 1, 0, 2'd3, ALL, ALL, "R6");
    step(0, 1, 0, 2'd3, ALL, ALL, "R6");
    step(0, 1, 1, 2'd3, ALL, ALL, "R6");
    step(1, 1, 1, 2'd3, NONE, NONE, "R7");

    // R1: reset asserted in the middle of an access
    step(0, 1, 1, 2'd1, 1, 1, "R3");
    @(negedge clk); rst_n = 1'b0;
    step(0, 0, 0, 2'd1, NONE, NONE, "R1");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule